// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave-side protocol engine of a 256-byte serial memory reached over a two-wire bus. It does not filter the bus. Instead it takes already-synchronised samples of the clock and data lines, together with one-cycle pulses that mark bus start and stop conditions. From these it counts bits and bytes and decodes the control byte. It pulls the data line low through an open-drain enable, both to acknowledge and to send read data.

The engine keeps one 8-bit address pointer. It supports single-byte and paged writes, reads from the current address, reads at a random address and sequential reads. Read data comes from a synchronous read port whose address is always the pointer. Each received data byte is handed to an external page buffer as a write request, and a stop condition asks that buffer to commit. While the external array reports a write cycle in progress, the engine acknowledges nothing, so a master can poll until the cycle ends.

Top module: `i2cee_slave_engine`

## Requirements
- R1: A control byte is received MSB first. Bits 7:4 must equal 1010. Bits 3:1 are ignored. Bit 0 selects the operation: 1 for read, 0 for write. A matching control byte is acknowledged by driving `sda_oe_o` high during the ninth clock.
- R2: A control byte whose bits 7:4 are not 1010 gets no acknowledge. Every following bit is then ignored until the next start or stop: no SDA drive and no write request.
- R3: While `busy_i` is high when a byte completes, that byte is not acknowledged. This includes a matching control byte.
- R4: In a write, the first byte after the control byte loads the pointer. Each later byte is acknowledged and produces a one-cycle `wr_en_o` carrying the pointer as `wr_addr_o` and the byte as `wr_data_o`.
- R5: After each written data byte, the low PAGE_BITS bits of the pointer (3 by default) increment modulo the page size, and the upper bits stay unchanged.
- R6: A stop after at least one written data byte pulses `commit_o` for one cycle. A stop with no data byte gives no commit, and neither does a write cut short by a repeated start.
- R7: A read that begins without first setting an address returns the byte at the pointer, which is one past the last accessed byte. After reset the pointer is 0.
- R8: A write control byte, then an address byte, then a repeated start and a read control byte, reads from the new address.
- R9: During a read, a master acknowledge after a byte makes the engine send the next byte. The pointer increments after every byte sent and wraps from 0xFF to 0x00.
- R10: A master no-acknowledge after a read byte makes the engine release SDA and stay silent until the next start or stop.
- R11: `sda_oe_o` changes only in the cycle after a sampled SCL falling edge, or after a start or stop pulse.
- R12: A start returns the engine to control-byte reception from any state, with SDA released. A stop returns it to idle with SDA released.
- R13: During and after reset, `sda_oe_o`, `wr_en_o` and `commit_o` are 0 and `rd_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock sample |
| sda_i | input | 1 | Synchronised serial data sample (wired bus level) |
| start_i | input | 1 | One-cycle pulse on a start condition |
| stop_i | input | 1 | One-cycle pulse on a stop condition |
| busy_i | input | 1 | High while the array performs a write cycle |
| rd_data_i | input | 8 | Data at `rd_addr_o`, one cycle after the address |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| rd_addr_o | output | 8 | Current pointer, used as the read address |
| wr_en_o | output | 1 | One-cycle write request to the page buffer |
| wr_addr_o | output | 8 | Address of the write request |
| wr_data_o | output | 8 | Data of the write request |
| commit_o | output | 1 | One-cycle request to commit the page buffer |

## Verification
The hardest state to reach is a control byte that completes while a write cycle is still running. The bench reaches it with an environment model that raises busy for a fixed time after each commit. It then polls with start and a write control byte until an acknowledge appears, and requires at least one refused poll before the accepted one. Page rollover inside a write and the 0xFF to 0x00 wrap of a sequential read are reached by choosing start addresses just below the boundaries. Throughout, a reference SDA enable computed from the bench's own memory image is compared with the design's output on every clock.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

    localparam int ADDR_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } wreq_t;

    function automatic logic ctrl_is_ours(input logic [7:0] b);
        return b[7:4] == DEV_CODE;
    endfunction

    function automatic logic st_active(input st_e s);
        return (s != ST_IDLE) && (s != ST_SKIP);
    endfunction

endpackage

// File: rtl/i2cee_scl_edge.sv
module i2cee_scl_edge (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q;

    always_ff @(posedge clk) begin
        if (rst) scl_q <= 1'b1;
        else     scl_q <= scl_i;
    end

    assign rise_o = scl_i & ~scl_q;
    assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2cee_bitseq.sv
module i2cee_bitseq #(
    parameter int BITS = 8,
    localparam int CW = $clog2(BITS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            shift,
    input  logic            bit_i,
    output logic [CW-1:0]   cnt_o,
    output logic [BITS-1:0] byte_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o  <= '0;
            byte_o <= '0;
        end else if (clr) begin
            cnt_o  <= '0;
        end else if (shift && cnt_o < CW'(BITS)) begin
            cnt_o  <= cnt_o + 1'b1;
            byte_o <= {byte_o[BITS-2:0], bit_i};
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= CW'(BITS));
endmodule

// File: rtl/i2cee_ptr.sv
module i2cee_ptr #(
    parameter int AW = 8,
    parameter int PAGE_BITS = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_full,
    input  logic          inc_page,
    output logic [AW-1:0] ptr_o
);
    always_ff @(posedge clk) begin
        if (rst)           ptr_o <= '0;
        else if (load)     ptr_o <= load_val;
        else if (inc_full) ptr_o <= ptr_o + 1'b1;
        else if (inc_page)
            ptr_o <= {ptr_o[AW-1:PAGE_BITS], ptr_o[PAGE_BITS-1:0] + 1'b1};
    end

    p_page_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (inc_page && !load && !inc_full) |=>
            ptr_o[AW-1:PAGE_BITS] == $past(ptr_o[AW-1:PAGE_BITS]));

    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (inc_full && !load && ptr_o == '1) |=> ptr_o == '0);
endmodule

// File: rtl/i2cee_slave_engine.sv
module i2cee_slave_engine #(
    parameter int PAGE_BITS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       busy_i,
    input  logic [7:0] rd_data_i,
    output logic       sda_oe_o,
    output logic [7:0] rd_addr_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       commit_o
);
    import i2cee_pkg::*;

    localparam int AW = ADDR_W;
    localparam int CW = $clog2(9);

    st_e           st;
    logic          ackph, mack, got_data;
    logic [7:0]    txr;
    wreq_t         wreq;
    logic          rise, fall;
    logic [CW-1:0] cnt;
    logic [7:0]    rbyte;
    logic [AW-1:0] ptr;
    logic          byte_done, bit_clr, bit_shift;

    i2cee_scl_edge u_edge (
        .clk(clk), .rst(rst), .scl_i(scl_i), .rise_o(rise), .fall_o(fall)
    );

    assign bit_clr   = start_i | stop_i | (fall & ackph);
    assign bit_shift = rise & ~ackph & st_active(st);

    i2cee_bitseq #(.BITS(8)) u_bits (
        .clk(clk), .rst(rst), .clr(bit_clr), .shift(bit_shift),
        .bit_i(sda_i), .cnt_o(cnt), .byte_o(rbyte)
    );

    assign byte_done = fall & ~ackph & (cnt == CW'(8)) & ~start_i & ~stop_i
                     & st_active(st);

    i2cee_ptr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk(clk), .rst(rst),
        .load(byte_done && st == ST_ADDR && !busy_i),
        .load_val(rbyte),
        .inc_full(byte_done && st == ST_RDATA),
        .inc_page(byte_done && st == ST_WDATA && !busy_i),
        .ptr_o(ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ackph    <= 1'b0;
            mack     <= 1'b0;
            got_data <= 1'b0;
            txr      <= '0;
            wreq     <= '0;
            sda_oe_o <= 1'b0;
            wr_en_o  <= 1'b0;
            commit_o <= 1'b0;
        end else begin
            wr_en_o  <= 1'b0;
            commit_o <= 1'b0;
            if (start_i) begin
                st       <= ST_CTRL;
                ackph    <= 1'b0;
                sda_oe_o <= 1'b0;
                got_data <= 1'b0;
            end else if (stop_i) begin
                st       <= ST_IDLE;
                ackph    <= 1'b0;
                sda_oe_o <= 1'b0;
                commit_o <= got_data;
                got_data <= 1'b0;
            end else if (byte_done) begin
                ackph <= 1'b1;
                unique case (st)
                    ST_CTRL: begin
                        if (ctrl_is_ours(rbyte) && !busy_i) begin
                            sda_oe_o <= 1'b1;
                            mack     <= 1'b1;
                            st       <= rbyte[0] ? ST_RDATA : ST_ADDR;
                        end else begin
                            sda_oe_o <= 1'b0;
                            st       <= ST_SKIP;
                        end
                    end
                    ST_ADDR: begin
                        sda_oe_o <= !busy_i;
                        st       <= ST_WDATA;
                    end
                    ST_WDATA: begin
                        sda_oe_o <= !busy_i;
                        wr_en_o  <= !busy_i;
                        wreq     <= '{addr: ptr, data: rbyte};
                        got_data <= got_data | !busy_i;
                    end
                    default: sda_oe_o <= 1'b0;
                endcase
            end else if (rise && ackph && st == ST_RDATA) begin
                mack <= ~sda_i;
            end else if (fall && ackph) begin
                ackph <= 1'b0;
                if (st == ST_RDATA && mack) begin
                    txr      <= rd_data_i;
                    sda_oe_o <= ~rd_data_i[7];
                end else begin
                    sda_oe_o <= 1'b0;
                    if (st == ST_RDATA) st <= ST_SKIP;
                end
            end else if (fall && st == ST_RDATA && cnt != '0 && cnt < CW'(8)) begin
                sda_oe_o <= ~txr[3'd7 - cnt[2:0]];
            end
        end
    end

    assign rd_addr_o = ptr;
    assign wr_addr_o = wreq.addr;
    assign wr_data_o = wreq.data;

    p_no_ack_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (byte_done && busy_i) |=> !sda_oe_o);

    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe_o) && !$past(start_i) && !$past(stop_i)) |-> !$past(scl_i));

    p_commit_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> $past(stop_i));

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP || st == ST_IDLE) |-> !sda_oe_o);

    p_write_source_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> ($past(st) == ST_WDATA && !$past(busy_i)));

    p_start_release_r12: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!sda_oe_o && st == ST_CTRL));
endmodule

// File: tb/i2cee_slave_engine_tb_top.sv
module i2cee_slave_engine_tb_top;
    localparam int BUSY_CYC = 250;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, sda_m = 1'b1, start_p = 1'b0, stop_p = 1'b0;
    logic busy_b = 1'b0;
    logic [7:0] rd_data = '0;
    logic sda_oe, wr_en, commit;
    logic [7:0] rd_addr, wr_addr, wr_data;
    wire  bus_sda = sda_m & ~sda_oe;

    int n_chk = 0, n_fail = 0, commits = 0, bcnt = 0;
    logic exp_oe = 1'b0;
    string cur_req = "R13";
    logic [7:0] mem  [256];
    logic [7:0] gold [256];
    logic [15:0] open_q[$], cmt_q[$], wlog[$];
    logic [7:0] ptr_m = 8'h00;

    always #10 clk = ~clk;

    i2cee_slave_engine dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(bus_sda),
        .start_i(start_p), .stop_i(stop_p), .busy_i(busy_b),
        .rd_data_i(rd_data), .sda_oe_o(sda_oe), .rd_addr_o(rd_addr),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .commit_o(commit)
    );

    // environment: page buffer, array and write-cycle timer
    always @(posedge clk) begin
        if (start_p) open_q.delete();
        if (wr_en) begin
            open_q.push_back({wr_addr, wr_data});
            wlog.push_back({wr_addr, wr_data});
        end
        if (commit) begin
            commits++;
            cmt_q = open_q;
            open_q.delete();
            busy_b <= 1'b1;
            bcnt   <= BUSY_CYC;
        end else if (busy_b) begin
            if (bcnt == 0) begin
                foreach (cmt_q[k]) mem[cmt_q[k][15:8]] = cmt_q[k][7:0];
                busy_b <= 1'b0;
            end else bcnt <= bcnt - 1;
        end
        rd_data <= mem[rd_addr];
    end

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    // per-clock comparison of the SDA enable against the reference
    always @(posedge clk) begin
        #5;
        if (!rst) chk(sda_oe === exp_oe, cur_req, sda_oe, exp_oe);
    end

    task automatic bit_cyc(input logic drv, input logic ef, input logic use_busy,
                           output logic smp);
        sda_m = drv;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (3) @(negedge clk);
        smp = bus_sda;
        scl = 1'b0;
        exp_oe = use_busy ? (ef & ~busy_b) : ef;
    endtask

    task automatic do_start();
        sda_m = 1'b1;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (2) @(negedge clk);
        sda_m = 1'b0; start_p = 1'b1; exp_oe = 1'b0;
        @(negedge clk) start_p = 1'b0;
        @(negedge clk) scl = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_stop();
        sda_m = 1'b0;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (2) @(negedge clk);
        sda_m = 1'b1; stop_p = 1'b1; exp_oe = 1'b0;
        @(negedge clk) stop_p = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic ack_exp, input logic e9,
                           output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], (i == 0) ? ack_exp : 1'b0, i == 0, s);
        bit_cyc(1'b1, e9, 1'b0, s);
        acked = ~s;
    endtask

    task automatic rd_byte(input logic [7:0] ev, input logic mack, input logic e9,
                           output logic [7:0] got);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, (i > 0) ? ~ev[(i > 0) ? i - 1 : 0] : 1'b0, 1'b0, s);
            got[i] = s;
        end
        bit_cyc(mack ? 1'b0 : 1'b1, e9, 1'b0, s);
    endtask

    // set pointer with a write, then repeated start and read n bytes
    task automatic rnd_read(input logic [7:0] a, input int n, input string req);
        logic ak;
        logic [7:0] g;
        cur_req = req;
        do_start();
        wr_byte(8'hA0, 1'b1, 1'b0, ak);
        chk(ak, req, ak, 1);
        wr_byte(a, 1'b1, 1'b0, ak);
        chk(ak, req, ak, 1);
        ptr_m = a;
        do_start();
        wr_byte(8'hA1, 1'b1, ~gold[ptr_m][7], ak);
        chk(ak, req, ak, 1);
        for (int k = 0; k < n; k++) begin
            logic last;
            last = (k == n - 1);
            rd_byte(gold[ptr_m], ~last, last ? 1'b0 : ~gold[8'(ptr_m + 1)][7], g);
            chk(g == gold[ptr_m], req, g, gold[ptr_m]);
            ptr_m = ptr_m + 1;
        end
        do_stop();
    endtask

    initial begin : main
        logic ak, saw_nack;
        logic [7:0] g;
        int c0, w0, polls;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'((i * 37 + 11) ^ (i >> 3));
            gold[i] = mem[i];
        end
        repeat (5) @(negedge clk);
        // R13: reset state
        chk(sda_oe == 0 && wr_en == 0 && commit == 0, "R13", sda_oe, 0);
        chk(rd_addr == 0, "R13", rd_addr, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R7: current-address read after reset reads address 0
        cur_req = "R7";
        do_start();
        wr_byte(8'hA1, 1'b1, ~gold[0][7], ak);
        chk(ak, "R7", ak, 1);
        rd_byte(gold[0], 1'b0, 1'b0, g);
        chk(g == gold[0], "R7", g, gold[0]);
        do_stop();
        ptr_m = 8'h01;
        chk(rd_addr == ptr_m, "R7", rd_addr, ptr_m);

        // R1 R4 R5 R6: page write with chip-select bits set, rolls within page
        cur_req = "R5";
        c0 = commits;
        wlog.delete();
        do_start();
        wr_byte(8'hAA, 1'b1, 1'b0, ak);
        chk(ak, "R1", ak, 1);
        wr_byte(8'h3E, 1'b1, 1'b0, ak);
        chk(ak, "R4", ak, 1);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] wa, wd;
            wa = {5'b00111, 3'(3'd6 + 3'(k))};
            wd = 8'hC0 + 8'(k);
            wr_byte(wd, 1'b1, 1'b0, ak);
            chk(ak, "R4", ak, 1);
            gold[wa] = wd;
        end
        do_stop();
        @(negedge clk);
        chk(commits == c0 + 1, "R6", commits, c0 + 1);
        chk(wlog.size() == 4, "R4", wlog.size(), 4);
        if (wlog.size() == 4) begin
            chk(wlog[0] == 16'h3EC0, "R4", wlog[0], 16'h3EC0);
            chk(wlog[1] == 16'h3FC1, "R5", wlog[1], 16'h3FC1);
            chk(wlog[2] == 16'h38C2, "R5", wlog[2], 16'h38C2);
            chk(wlog[3] == 16'h39C3, "R5", wlog[3], 16'h39C3);
        end
        chk(rd_addr == 8'h3A, "R5", rd_addr, 8'h3A);

        // R3: acknowledge polling during the write cycle
        cur_req = "R3";
        saw_nack = 1'b0;
        polls = 0;
        ak = 1'b0;
        while (!ak && polls < 20) begin
            logic pred;
            do_start();
            pred = ~busy_b;
            wr_byte(8'hA0, 1'b1, 1'b0, ak);
            if (!ak) saw_nack = 1'b1;
            do_stop();
            polls++;
        end
        chk(saw_nack, "R3", saw_nack, 1);
        chk(ak, "R3", ak, 1);
        chk(commits == c0 + 1, "R6", commits, c0 + 1);

        // R8 R9: random read then sequential across the page that was written
        rnd_read(8'h3D, 5, "R8");
        // R7: continue from last accessed + 1
        cur_req = "R7";
        do_start();
        wr_byte(8'hA1, 1'b1, ~gold[ptr_m][7], ak);
        chk(ak, "R7", ak, 1);
        rd_byte(gold[ptr_m], 1'b0, 1'b0, g);
        chk(g == gold[ptr_m], "R7", g, gold[ptr_m]);
        do_stop();
        ptr_m = ptr_m + 1;

        // R2: foreign device code is ignored
        cur_req = "R2";
        w0 = wlog.size();
        do_start();
        wr_byte(8'h50, 1'b0, 1'b0, ak);
        chk(!ak, "R2", ak, 0);
        wr_byte(8'h12, 1'b0, 1'b0, ak);
        chk(!ak, "R2", ak, 0);
        wr_byte(8'h34, 1'b0, 1'b0, ak);
        chk(!ak, "R2", ak, 0);
        do_stop();
        chk(wlog.size() == w0, "R2", wlog.size(), w0);
        chk(rd_addr == ptr_m, "R2", rd_addr, ptr_m);

        // R9: sequential read wraps FF to 00
        rnd_read(8'hFE, 3, "R9");
        chk(rd_addr == 8'h01, "R9", rd_addr, 8'h01);

        // R6 R12: write cut by repeated start, then read; no commit
        cur_req = "R12";
        c0 = commits;
        do_start();
        wr_byte(8'hA0, 1'b1, 1'b0, ak);
        wr_byte(8'h10, 1'b1, 1'b0, ak);
        wr_byte(8'h55, 1'b1, 1'b0, ak);
        chk(ak, "R4", ak, 1);
        ptr_m = 8'h11;
        do_start();
        wr_byte(8'hA1, 1'b1, ~gold[ptr_m][7], ak);
        chk(ak, "R12", ak, 1);
        rd_byte(gold[ptr_m], 1'b0, 1'b0, g);
        chk(g == gold[ptr_m], "R12", g, gold[ptr_m]);
        // R10: after NACK further clocks produce no drive
        cur_req = "R10";
        wr_byte(8'hFF, 1'b0, 1'b0, ak);
        chk(!ak, "R10", ak, 0);
        do_stop();
        repeat (2 * BUSY_CYC) @(negedge clk);
        chk(commits == c0, "R6", commits, c0);
        chk(mem[8'h10] == gold[8'h10], "R6", mem[8'h10], gold[8'h10]);
        // R11 is covered by the per-clock SDA enable comparison throughout
        cur_req = "R11";
        rnd_read(8'h80, 2, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule